// File: doc/BRIEF.md
# I2C Target with Dual Address Match

This block is the target side of a two-wire serial bus. It watches the clock and data lines through synchronisers and finds START and STOP conditions. It shifts in the address byte and compares the seven address bits with two programmable addresses. When enabled, it also accepts the all-zero broadcast address. After a match it works as a receiver or as a transmitter, as the direction bit of the address byte selects. It passes bytes to and from local logic through one receive register and one transmit register.

Both lines are open-drain. The block never drives a line high: it only asserts an output enable that pulls the line low. When local logic is late, the block holds the clock low until a received byte has been read or a byte to send has been written. With stretching switched off it never touches the clock line. It then flags the lost or missing byte instead. Sticky flags report a STOP after an acknowledged transfer, a misplaced START or STOP, and data loss. A single pulse clears them.

Top module: `i2c_dual_target`

## Requirements
- R1: After reset both line enables are low, `tx_empty` is 1, and `rx_full`, `addr_hit`, `hit_second`, `gc_hit`, `xmit_mode`, `stop_seen`, `overrun` and `bus_err` are 0.
- R2: An address byte whose upper seven bits equal `own_addr_a` or `own_addr_b` is acknowledged by pulling SDA low for the ninth clock. `addr_hit` sets, and `hit_second` reads 0 for address A and 1 for address B. A non-zero own address never matches address 0.
- R3: Address 0 with direction bit 0 is acknowledged only when `gc_en` is 1, and then `gc_hit` sets. With `gc_en` at 0 it is not acknowledged.
- R4: After an address that does not match, the block drives neither line until the next START, and `addr_hit` stays 0.
- R5: `xmit_mode` takes the direction bit (the last address bit) of a matched address: 1 means the target sends and 0 means it receives. A repeated START followed by a new address updates it.
- R6: In receive mode each byte is taken MSB first and acknowledged. It is placed in `rx_data` and sets `rx_full`, and only a pulse on `rx_read` clears `rx_full`.
- R7: A byte written by a `tx_load` pulse is sent MSB first and sets `tx_empty` when it is taken for sending. The target releases SDA during the acknowledge clock.
- R8: When the controller acknowledges a sent byte, the next byte follows. When it does not, the target releases SDA and stays idle until a STOP or a repeated START.
- R9: With `stretch_off` at 0, a received byte that completes while `rx_full` is 1 makes the target hold SCL low before the acknowledge clock. It keeps SCL low until `rx_read` pulses, and then stores the new byte.
- R10: With `stretch_off` at 0, if the target must send while `tx_empty` is 1, it holds SCL low until `tx_load` pulses, and then sends that byte.
- R11: With `stretch_off` at 1 the target never drives SCL. A byte that arrives while `rx_full` is 1 is still acknowledged but dropped, and `rx_data` keeps its old value. A byte needed while `tx_empty` is 1 is sent as 0xFF. In both cases `overrun` sets.
- R12: `stop_seen` sets on a STOP that follows an acknowledged address, and not on a STOP after a rejected one. A `flag_clr` pulse clears `stop_seen`, `overrun` and `bus_err`.
- R13: `bus_err` sets when a START or STOP arrives after two or more bits of a byte have been clocked. A repeated START placed right after an acknowledge does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Level seen on the bus clock line |
| sda_i | input | 1 | Level seen on the bus data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr_a | input | 7 | First own address |
| own_addr_b | input | 7 | Second own address |
| gc_en | input | 1 | Accept the all-zero broadcast address |
| stretch_off | input | 1 | 1 disables clock stretching |
| flag_clr | input | 1 | Pulse clears stop_seen, overrun and bus_err |
| rx_data | output | 8 | Last received byte |
| rx_read | input | 1 | Pulse: local logic has taken rx_data |
| rx_full | output | 1 | rx_data holds an unread byte |
| tx_data | input | 8 | Byte to send |
| tx_load | input | 1 | Pulse: capture tx_data |
| tx_empty | output | 1 | No byte waiting to be sent |
| addr_hit | output | 1 | Current transfer is addressed to this target |
| hit_second | output | 1 | Last match was own_addr_b |
| gc_hit | output | 1 | Last match was the broadcast address |
| xmit_mode | output | 1 | Direction of the last match, 1 means send |
| stop_seen | output | 1 | Sticky: STOP after an acknowledged transfer |
| overrun | output | 1 | Sticky: byte lost or underrun without stretching |
| bus_err | output | 1 | Sticky: START or STOP in the middle of a byte |

## Verification
The main function is exercised by a table of address bytes that contains address A and address B in both directions, the broadcast address with and without its enable, and an unrelated address. These cases show the two address comparators apart, the broadcast gating apart from a plain match, and a match apart from a rejection. Each acknowledged write is then checked through its data byte, and each read through the byte on the bus. Directed sequences then cover stretching on both paths by raising `rx_read` or `tx_load` only while SCL is held. They also cover loss and underrun with stretching off, a two-byte read that ends in a NACK, a repeated START that turns a write into a read, and a STOP after four bits of an address.

// File: rtl/i2c_dual_target.sv
module i2c_dual_target (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [6:0] own_addr_a,
  input  logic [6:0] own_addr_b,
  input  logic       gc_en,
  input  logic       stretch_off,
  input  logic       flag_clr,
  output logic [7:0] rx_data,
  input  logic       rx_read,
  output logic       rx_full,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  output logic       tx_empty,
  output logic       addr_hit,
  output logic       hit_second,
  output logic       gc_hit,
  output logic       xmit_mode,
  output logic       stop_seen,
  output logic       overrun,
  output logic       bus_err
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RHOLD, ST_RACK,
    ST_TLOAD, ST_TX, ST_TACK, ST_WAIT
  } st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [7:0] shift, tx_reg;
  logic [3:0] cnt;
  logic       scl_drv, sda_drv, ack_n;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  wire [6:0] rx_addr = shift[7:1];
  wire m_a  = (rx_addr == own_addr_a) && (rx_addr != 7'd0);
  wire m_b  = (rx_addr == own_addr_b) && (rx_addr != 7'd0);
  wire m_gc = (rx_addr == 7'd0) && !shift[0] && gc_en;

  wire mid_byte = ((st == ST_ADDR || st == ST_RX) && cnt >= 4'd2) || st == ST_TX;
  wire rx_room  = !rx_full || rx_read;

  assign scl_oe = scl_drv;
  assign sda_oe = sda_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= ST_IDLE; shift <= '0; tx_reg <= '0; cnt <= '0;
      scl_drv <= 1'b0; sda_drv <= 1'b0; ack_n <= 1'b1;
      rx_data <= '0; rx_full <= 1'b0; tx_empty <= 1'b1;
      addr_hit <= 1'b0; hit_second <= 1'b0; gc_hit <= 1'b0; xmit_mode <= 1'b0;
      stop_seen <= 1'b0; overrun <= 1'b0; bus_err <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (rx_read) rx_full <= 1'b0;
      if (flag_clr) begin
        stop_seen <= 1'b0; overrun <= 1'b0; bus_err <= 1'b0;
      end
      if (start_det || stop_det) begin
        if (mid_byte) bus_err <= 1'b1;
        if (stop_det && addr_hit) stop_seen <= 1'b1;
        addr_hit <= 1'b0;
        sda_drv  <= 1'b0;
        scl_drv  <= 1'b0;
        cnt      <= '0;
        st       <= start_det ? ST_ADDR : ST_IDLE;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shift <= {shift[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (m_a || m_b || m_gc) begin
                addr_hit   <= 1'b1;
                hit_second <= !m_a && m_b;
                gc_hit     <= m_gc;
                xmit_mode  <= shift[0];
                sda_drv    <= 1'b1;
                st         <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_drv <= 1'b0;
              cnt     <= '0;
              st      <= xmit_mode ? ST_TLOAD : ST_RX;
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shift <= {shift[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (rx_room) begin
                rx_data <= shift;
                rx_full <= 1'b1;
                sda_drv <= 1'b1;
                st      <= ST_RACK;
              end else if (stretch_off) begin
                overrun <= 1'b1;
                sda_drv <= 1'b1;
                st      <= ST_RACK;
              end else begin
                scl_drv <= 1'b1;
                st      <= ST_RHOLD;
              end
            end
          end
          ST_RHOLD: begin
            if (rx_room) begin
              rx_data <= shift;
              rx_full <= 1'b1;
              sda_drv <= 1'b1;
              scl_drv <= 1'b0;
              st      <= ST_RACK;
            end else if (stretch_off) begin
              overrun <= 1'b1;
              sda_drv <= 1'b1;
              scl_drv <= 1'b0;
              st      <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_drv <= 1'b0;
              cnt     <= '0;
              st      <= ST_RX;
            end
          end
          ST_TLOAD: begin
            if (!tx_empty) begin
              shift    <= tx_reg;
              tx_empty <= 1'b1;
              sda_drv  <= !tx_reg[7];
              scl_drv  <= 1'b0;
              cnt      <= '0;
              st       <= ST_TX;
            end else if (stretch_off) begin
              shift   <= 8'hFF;
              overrun <= 1'b1;
              sda_drv <= 1'b0;
              scl_drv <= 1'b0;
              cnt     <= '0;
              st      <= ST_TX;
            end else begin
              scl_drv <= 1'b1;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_drv <= 1'b0;
                st      <= ST_TACK;
              end else begin
                shift   <= {shift[6:0], 1'b0};
                sda_drv <= !shift[6];
                cnt     <= cnt + 4'd1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) ack_n <= sda_s;
            else if (scl_fall) st <= ack_n ? ST_WAIT : ST_TLOAD;
          end
          default: ;
        endcase
      end
      if (tx_load) begin
        tx_reg   <= tx_data;
        tx_empty <= 1'b0;
      end
    end
  end

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> !sda_oe && !scl_oe);

  // R9
  stretch_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (st == ST_RHOLD || st == ST_TLOAD));

  // R11
  nostretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_off |=> !scl_oe);

  // R6
  rxfull_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(rx_read));

  // R2
  ack_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_hit) |-> sda_oe);

  // R12
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> $past(stop_det));

endmodule

// File: tb/sim_i2c_dual_target.sv
module sim_i2c_dual_target;
  localparam int Q = 25;
  localparam logic [6:0] ADR_A = 7'h3A;
  localparam logic [6:0] ADR_B = 7'h51;
  // {gc_en, addr[6:0], rw, data[7:0], exp_ack, exp_second, exp_gc}
  localparam logic [19:0] VEC [7] = '{
    {1'b0, 7'h3A, 1'b0, 8'hC3, 1'b1, 1'b0, 1'b0},
    {1'b0, 7'h51, 1'b0, 8'h5A, 1'b1, 1'b1, 1'b0},
    {1'b1, 7'h00, 1'b0, 8'h81, 1'b1, 1'b0, 1'b1},
    {1'b0, 7'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 7'h22, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 7'h3A, 1'b1, 8'h96, 1'b1, 1'b0, 1'b0},
    {1'b0, 7'h51, 1'b1, 8'h4E, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic gc_en = 1'b0, stretch_off = 1'b0, flag_clr = 1'b0;
  logic rx_read = 1'b0, tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic scl_oe, sda_oe, rx_full, tx_empty, addr_hit, hit_second, gc_hit;
  logic xmit_mode, stop_seen, overrun, bus_err;
  logic [7:0] rx_data;
  int checks = 0, fails = 0;
  int scl_cyc = 0, sda_cyc = 0;

  wire scl_bus = scl_m & ~scl_oe;
  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (scl_oe) scl_cyc <= scl_cyc + 1;
    if (sda_oe) sda_cyc <= sda_cyc + 1;
  end

  i2c_dual_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr_a(ADR_A), .own_addr_b(ADR_B),
    .gc_en(gc_en), .stretch_off(stretch_off), .flag_clr(flag_clr),
    .rx_data(rx_data), .rx_read(rx_read), .rx_full(rx_full),
    .tx_data(tx_data), .tx_load(tx_load), .tx_empty(tx_empty),
    .addr_hit(addr_hit), .hit_second(hit_second), .gc_hit(gc_hit),
    .xmit_mode(xmit_mode), .stop_seen(stop_seen), .overrun(overrun),
    .bus_err(bus_err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; wait_high(); tick(Q);
    r = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait_high(); tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; wait_high(); tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(!ack, r);
  endtask

  task automatic pulse_read();
    rx_read = 1'b1; tick(1); rx_read = 1'b0; tick(1);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1);
  endtask

  task automatic load_tx(input logic [7:0] d);
    tx_data = d; tx_load = 1'b1; tick(1); tx_load = 1'b0; tick(1);
  endtask

  task automatic wait_stretch();
    while (!scl_oe) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d, d2;
    int snap;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk("R1 oe", {30'd0, scl_oe, sda_oe}, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 flags", {rx_full, addr_hit, hit_second, gc_hit, xmit_mode, stop_seen, overrun, bus_err}, 0);

    for (int i = 0; i < 7; i++) begin
      logic [19:0] v;
      v = VEC[i];
      gc_en = v[19];
      if (v[11]) load_tx(v[10:3]);
      snap = sda_cyc;
      i2c_start();
      send_byte({v[18:12], v[11]}, ack);
      chk("R2/R3/R4 address ack", ack, v[2]);
      if (v[2]) begin
        chk("R2 addr_hit", addr_hit, 1);
        chk("R2 hit_second", hit_second, v[1]);
        chk("R3 gc_hit", gc_hit, v[0]);
        chk("R5 xmit_mode", xmit_mode, v[11]);
        if (!v[11]) begin
          send_byte(v[10:3], ack);
          chk("R6 data ack", ack, 1);
          chk("R6 rx_full", rx_full, 1);
          chk("R6 rx_data", rx_data, v[10:3]);
          pulse_read();
          chk("R6 rx_read clears", rx_full, 0);
        end else begin
          recv_byte(1'b0, d);
          chk("R7 sent byte", d, v[10:3]);
          chk("R7 tx_empty", tx_empty, 1);
          tick(5);
          chk("R8 sda released after nack", sda_oe, 0);
        end
        i2c_stop();
        tick(5);
        chk("R12 stop_seen", stop_seen, 1);
        pulse_clr();
        chk("R12 clear", stop_seen, 0);
      end else begin
        chk("R4 addr_hit low", addr_hit, 0);
        i2c_stop();
        tick(5);
        chk("R4 no sda drive", sda_cyc - snap, 0);
        chk("R12 no stop flag", stop_seen, 0);
      end
    end
    gc_en = 1'b0;

    // R9 receive stretching
    i2c_start();
    send_byte({ADR_A, 1'b0}, ack);
    send_byte(8'h11, ack);
    fork
      send_byte(8'h3C, ack);
      begin
        wait_stretch(); tick(40);
        chk("R9 scl held", {scl_oe, scl_bus}, 2'b10);
        chk("R9 old byte kept", rx_data, 8'h11);
        pulse_read();
      end
    join
    chk("R9 ack after read", ack, 1);
    chk("R9 new byte", rx_data, 8'h3C);
    pulse_read();
    i2c_stop();
    pulse_clr();

    // R11 receive loss without stretching
    stretch_off = 1'b1;
    snap = scl_cyc;
    i2c_start();
    send_byte({ADR_A, 1'b0}, ack);
    send_byte(8'h44, ack);
    send_byte(8'h22, ack);
    chk("R11 ack on loss", ack, 1);
    chk("R11 overrun", overrun, 1);
    chk("R11 rx_data kept", rx_data, 8'h44);
    i2c_stop();
    pulse_read();
    pulse_clr();
    chk("R12 overrun cleared", overrun, 0);

    // R11 transmit underrun
    i2c_start();
    send_byte({ADR_A, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk("R11 underrun byte", d, 8'hFF);
    chk("R11 underrun flag", overrun, 1);
    i2c_stop();
    tick(5);
    chk("R11 scl never driven", scl_cyc - snap, 0);
    pulse_clr();
    stretch_off = 1'b0;

    // R10 transmit stretching, R8 acked then nacked read
    i2c_start();
    send_byte({ADR_A, 1'b1}, ack);
    fork
      recv_byte(1'b1, d);
      begin
        wait_stretch(); tick(30);
        chk("R10 scl held", {scl_oe, scl_bus}, 2'b10);
        load_tx(8'hA5);
      end
    join
    chk("R10 byte after load", d, 8'hA5);
    fork
      recv_byte(1'b0, d2);
      begin
        wait_stretch(); tick(10);
        load_tx(8'h3C);
      end
    join
    chk("R8 next byte after ack", d2, 8'h3C);
    tick(Q);
    chk("R8 sda released", sda_oe, 0);
    i2c_stop();
    tick(5);
    chk("R12 stop after read", stop_seen, 1);
    pulse_clr();

    // R5 repeated start switches direction, R13 no error
    i2c_start();
    send_byte({ADR_B, 1'b0}, ack);
    send_byte(8'h77, ack);
    chk("R6 write before restart", rx_data, 8'h77);
    pulse_read();
    load_tx(8'h19);
    i2c_start();
    send_byte({ADR_B, 1'b1}, ack);
    chk("R5 direction after restart", xmit_mode, 1);
    chk("R13 restart not error", bus_err, 0);
    recv_byte(1'b0, d);
    chk("R7 byte after restart", d, 8'h19);
    i2c_stop();
    pulse_clr();

    // R13 stop in the middle of an address byte
    i2c_start();
    for (int i = 0; i < 4; i++) clk_bit(ADR_A[6-i], ack);
    i2c_stop();
    tick(5);
    chk("R13 bus_err", bus_err, 1);
    chk("R12 no stop flag on abort", stop_seen, 0);
    pulse_clr();
    chk("R12 bus_err cleared", bus_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule